// File: doc/BRIEF.md
# PHY register access control register

This block is one 32-bit control and status word. Host software uses it to reach the internal registers of an attached physical-layer device. To start an access, the host writes a register address, optional write data, and a read-request or write-request flag. While a flag is set, the block offers the pending access to a separate link-to-PHY request engine. The engine signals with a one-cycle pulse that the access has been delivered, and the block then drops the flag it was serving. The host can therefore poll the flag bits to learn when its access has gone out.

When the PHY answers a read, it returns a register address and a data byte. The block latches both into two response fields of the same word. These fields are normally read-only. While an external diagnostic write-enable input is high, host writes also load them. A synchronous software reset clears the whole word, in the same way as the asynchronous power-up reset.

Top module: `phy_acc_ctrl`

## Requirements
- R1: After rst_n low, or after a cycle with sw_rst high, host_rdata reads 0 and req_valid is 0. sw_rst overrides every other input in that cycle.
- R2: The word layout has bit 31 as the read flag and bit 30 as the write flag. Bits 27:24 hold the target address, bits 23:16 the write data, bits 11:8 the returned address and bits 7:0 the returned data. A host write loads the target address and write-data fields, and the new values read back from the next cycle.
- R3: Bits 29:28 and 15:12 always read 0, whatever the host writes.
- R4: A host write with a 1 in a flag bit sets that flag. A host write with a 0 in a flag bit leaves that flag as it was.
- R5: req_valid is 1 exactly when at least one flag is set. req_addr and req_wdata show the target address and write-data fields. A set flag stays set until req_sent arrives for it.
- R6: req_sent clears the flag being served in the next cycle and leaves the other flag set. req_sent with no flag set changes nothing.
- R7: When both flags are set, the read is served first (req_is_write = 0). After its req_sent, the write is offered (req_is_write = 1).
- R8: A host write that sets a flag in the same cycle as req_sent for that flag leaves the flag set.
- R9: A resp_valid pulse loads resp_addr into bits 11:8 and resp_data into bits 7:0, visible from the next cycle.
- R10: Host writes leave bits 11:0 unchanged while diag_wr_en is 0. Host writes load bits 11:0 while diag_wr_en is 1.
- R11: When resp_valid and a diagnostic host write fall in the same cycle, the PHY response is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Register read-back word |
| diag_wr_en | input | 1 | Makes the response fields host-writable |
| req_valid | output | 1 | An access is pending |
| req_is_write | output | 1 | Pending access is a write |
| req_addr | output | 4 | Target PHY register address |
| req_wdata | output | 8 | Data for a write access |
| req_sent | input | 1 | Engine pulse: offered access delivered |
| resp_valid | input | 1 | PHY read response pulse |
| resp_addr | input | 4 | Address returned by the PHY |
| resp_data | input | 8 | Data returned by the PHY |

## Verification
The assertions assume the following of the engine: req_sent and resp_valid are single-cycle pulses, and req_sent refers to the access offered in that same cycle. They make no assumption that req_sent is raised only while req_valid is high. The stimulus therefore deliberately pulses req_sent when no flag is set, and pairs it with host writes that re-arm the served flag. Every input is driven between clock edges and stays stable across the edge that samples it. Pulse inputs are returned to 0 right after that edge, which keeps each pulse one cycle long, as the assertions assume.

// File: rtl/phyacc_pkg.sv
package phyacc_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned REG_AW    = 4;
  localparam int unsigned REG_DW    = 8;
  localparam int unsigned NUM_REQ   = 2;
  localparam int unsigned REQ_RD    = 0;
  localparam int unsigned REQ_WR    = 1;
  localparam int unsigned RD_BIT    = WORD_W - 1;
  localparam int unsigned WR_BIT    = WORD_W - 2;
  localparam int unsigned ADDR_LSB  = WORD_W - 4 - REG_AW;
  localparam int unsigned WDAT_LSB  = ADDR_LSB - REG_DW;
  localparam int unsigned CDAT_LSB  = 0;
  localparam int unsigned CADDR_LSB = CDAT_LSB + REG_DW;

  function automatic logic [REG_AW-1:0] fld_addr(input logic [WORD_W-1:0] w);
    return w[ADDR_LSB +: REG_AW];
  endfunction

  function automatic logic [REG_DW-1:0] fld_wdata(input logic [WORD_W-1:0] w);
    return w[WDAT_LSB +: REG_DW];
  endfunction

  function automatic logic [REG_AW-1:0] fld_caddr(input logic [WORD_W-1:0] w);
    return w[CADDR_LSB +: REG_AW];
  endfunction

  function automatic logic [REG_DW-1:0] fld_cdata(input logic [WORD_W-1:0] w);
    return w[CDAT_LSB +: REG_DW];
  endfunction

  function automatic logic [NUM_REQ-1:0] fld_flags(input logic [WORD_W-1:0] w);
    logic [NUM_REQ-1:0] f;
    f[REQ_RD] = w[RD_BIT];
    f[REQ_WR] = w[WR_BIT];
    return f;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(
    input logic [NUM_REQ-1:0] flags,
    input logic [REG_AW-1:0]  addr,
    input logic [REG_DW-1:0]  wdat,
    input logic [REG_AW-1:0]  caddr,
    input logic [REG_DW-1:0]  cdat
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[RD_BIT] = flags[REQ_RD];
    w[WR_BIT] = flags[REQ_WR];
    w[ADDR_LSB  +: REG_AW] = addr;
    w[WDAT_LSB  +: REG_DW] = wdat;
    w[CADDR_LSB +: REG_AW] = caddr;
    w[CDAT_LSB  +: REG_DW] = cdat;
    return w;
  endfunction
endpackage

// File: rtl/phyacc_req_ctl.sv
module phyacc_req_ctl
  import phyacc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_rst,
  input  logic [NUM_REQ-1:0] set_req,
  input  logic               req_sent,
  output logic [NUM_REQ-1:0] flags,
  output logic [NUM_REQ-1:0] serve,
  output logic               req_valid,
  output logic               req_is_write
);
  // serve: one-hot choice of the access offered now, read before write
  assign serve[REQ_RD] = flags[REQ_RD];
  assign serve[REQ_WR] = flags[REQ_WR] & ~flags[REQ_RD];
  assign req_valid     = |flags;
  assign req_is_write  = serve[REQ_WR];

  logic [NUM_REQ-1:0] done_ev;
  assign done_ev = serve & {NUM_REQ{req_sent}};

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[g] <= 1'b0;
      else if (sw_rst) flags[g] <= 1'b0;
      else             flags[g] <= set_req[g] | (flags[g] & ~done_ev[g]);
    end

    // R5: a pending flag survives every cycle without req_sent
    a_r5_hold_until_sent: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[g] && !req_sent && !sw_rst) |=> flags[g]);
    // R6: the served flag drops after req_sent unless re-armed
    a_r6_served_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (serve[g] && req_sent && !set_req[g] && !sw_rst) |=> !flags[g]);
    // R8: re-arm in the delivery cycle wins
    a_r8_rearm_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (serve[g] && req_sent && set_req[g] && !sw_rst) |=> flags[g]);
  end

  // R7: after the read goes out, a waiting write becomes the offered access
  a_r7_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (serve[REQ_RD] && flags[REQ_WR] && req_sent && !set_req[REQ_RD] && !sw_rst)
      |=> (req_valid && req_is_write));
  // R6: req_sent with nothing pending leaves the flags alone
  a_r6_idle_sent: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && req_sent && set_req == '0 && !sw_rst) |=> !req_valid);
endmodule

// File: rtl/phyacc_resp_cap.sv
module phyacc_resp_cap
  import phyacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              resp_valid,
  input  logic [REG_AW-1:0] resp_addr,
  input  logic [REG_DW-1:0] resp_data,
  input  logic              diag_load,
  input  logic [REG_AW-1:0] host_caddr,
  input  logic [REG_DW-1:0] host_cdata,
  output logic [REG_AW-1:0] cap_addr,
  output logic [REG_DW-1:0] cap_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_data <= '0;
    end else if (sw_rst) begin
      cap_addr <= '0;
      cap_data <= '0;
    end else if (resp_valid) begin
      cap_addr <= resp_addr;
      cap_data <= resp_data;
    end else if (diag_load) begin
      cap_addr <= host_caddr;
      cap_data <= host_cdata;
    end
  end

  // R9, R11: a PHY response always lands, even against a diagnostic write
  a_r9_resp_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !sw_rst) |=> (cap_addr == $past(resp_addr) && cap_data == $past(resp_data)));
  // R10: without a response or diagnostic load the fields hold
  a_r10_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!resp_valid && !diag_load && !sw_rst) |=> ($stable(cap_addr) && $stable(cap_data)));
  // R10: diagnostic load alone copies host data
  a_r10_diag_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (!resp_valid && diag_load && !sw_rst) |=> (cap_addr == $past(host_caddr) && cap_data == $past(host_cdata)));
endmodule

// File: rtl/phy_acc_ctrl.sv
module phy_acc_ctrl
  import phyacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              host_wr_en,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              diag_wr_en,
  output logic              req_valid,
  output logic              req_is_write,
  output logic [REG_AW-1:0] req_addr,
  output logic [REG_DW-1:0] req_wdata,
  input  logic              req_sent,
  input  logic              resp_valid,
  input  logic [REG_AW-1:0] resp_addr,
  input  logic [REG_DW-1:0] resp_data
);
  logic [REG_AW-1:0]  addr_q;
  logic [REG_DW-1:0]  wdat_q;
  logic [REG_AW-1:0]  cap_addr;
  logic [REG_DW-1:0]  cap_data;
  logic [NUM_REQ-1:0] flags;
  logic [NUM_REQ-1:0] serve;
  logic [NUM_REQ-1:0] set_req;
  logic               diag_load;

  // named events for the checks below
  assign set_req   = host_wr_en ? fld_flags(host_wdata) : '0;
  assign diag_load = host_wr_en & diag_wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (sw_rst) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (host_wr_en) begin
      addr_q <= fld_addr(host_wdata);
      wdat_q <= fld_wdata(host_wdata);
    end
  end

  phyacc_req_ctl u_req (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_rst       (sw_rst),
    .set_req      (set_req),
    .req_sent     (req_sent),
    .flags        (flags),
    .serve        (serve),
    .req_valid    (req_valid),
    .req_is_write (req_is_write)
  );

  phyacc_resp_cap u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_rst     (sw_rst),
    .resp_valid (resp_valid),
    .resp_addr  (resp_addr),
    .resp_data  (resp_data),
    .diag_load  (diag_load),
    .host_caddr (fld_caddr(host_wdata)),
    .host_cdata (fld_cdata(host_wdata)),
    .cap_addr   (cap_addr),
    .cap_data   (cap_data)
  );

  assign req_addr   = addr_q;
  assign req_wdata  = wdat_q;
  assign host_rdata = pack_word(flags, addr_q, wdat_q, cap_addr, cap_data);

  // R1: software reset empties the word
  a_r1_sw_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (host_rdata == '0 && !req_valid));
  // R3: spare bits never carry a value
  a_r3_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata[29:28] == 2'b00 && host_rdata[15:12] == 4'h0));
  // R2: a host write shows up in the target fields next cycle
  a_r2_fields_written: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && !sw_rst) |=> (req_addr == $past(host_wdata[27:24]) && req_wdata == $past(host_wdata[23:16])));
  // R4: writing a 0 flag bit never drops a pending request
  a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && !host_wdata[31] && host_rdata[31] && !req_sent && !sw_rst) |=> host_rdata[31]);
endmodule

// File: tb/phy_acc_ctrl_bench.sv
module phy_acc_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0, host_wr_en = 1'b0, diag_wr_en = 1'b0;
  logic        req_sent = 1'b0, resp_valid = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [3:0]  resp_addr = '0;
  logic [7:0]  resp_data = '0;
  logic [31:0] host_rdata;
  logic        req_valid, req_is_write;
  logic [3:0]  req_addr;
  logic [7:0]  req_wdata;

  always #4 clk = ~clk;

  phy_acc_ctrl u_phy_acc_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .host_wr_en(host_wr_en),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .diag_wr_en(diag_wr_en),
    .req_valid(req_valid), .req_is_write(req_is_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_sent(req_sent), .resp_valid(resp_valid),
    .resp_addr(resp_addr), .resp_data(resp_data)
  );

  typedef struct {
    logic [31:0] word;
    string       tag;
  } exp_t;
  exp_t q[$];

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // reference state, kept from the requirement text
  logic       m_rd = 0, m_wr = 0;
  logic [3:0] m_addr = 0, m_caddr = 0;
  logic [7:0] m_wd = 0, m_cdat = 0;

  function automatic logic [31:0] model_word();
    return {m_rd, m_wr, 2'b00, m_addr, m_wd, 4'h0, m_caddr, m_cdat};
  endfunction

  task automatic step(input logic we, input logic [31:0] wd, input logic dg,
                      input logic snt, input logic rv, input logic [3:0] ra,
                      input logic [7:0] rdd, input logic sr, input string tag);
    logic n_rd, n_wr;
    @(negedge clk);
    host_wr_en = we; host_wdata = wd; diag_wr_en = dg; req_sent = snt;
    resp_valid = rv; resp_addr = ra; resp_data = rdd; sw_rst = sr;
    if (sr) begin
      m_rd = 0; m_wr = 0; m_addr = 0; m_wd = 0; m_caddr = 0; m_cdat = 0;
    end else begin
      n_rd = (m_rd && !snt) || (we && wd[31]);
      n_wr = (m_wr && !(snt && !m_rd)) || (we && wd[30]);
      if (we) begin m_addr = wd[27:24]; m_wd = wd[23:16]; end
      if (rv) begin m_caddr = ra; m_cdat = rdd; end
      else if (we && dg) begin m_caddr = wd[11:8]; m_cdat = wd[7:0]; end
      m_rd = n_rd; m_wr = n_wr;
    end
    q.push_back('{model_word(), tag});
    @(posedge clk);
    #1;
    host_wr_en = 0; diag_wr_en = 0; req_sent = 0; resp_valid = 0; sw_rst = 0;
  endtask

  task automatic idle(input string tag);
    step(0, 32'h0, 0, 0, 0, 4'h0, 8'h0, 0, tag);
  endtask

  // monitor: compare every queued expectation after its edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        logic ev, ew;
        e = q.pop_front();
        ev = e.word[31] | e.word[30];
        ew = !e.word[31];
        checks++;
        if (host_rdata !== e.word || req_valid !== ev || (ev && req_is_write !== ew)
            || req_addr !== e.word[27:24] || req_wdata !== e.word[23:16]) begin
          fails++;
          $display("FAIL %s: rdata=%h valid=%b wr=%b addr=%h wdata=%h expected rdata=%h valid=%b wr=%b",
                   e.tag, host_rdata, req_valid, req_is_write, req_addr, req_wdata, e.word, ev, ew);
        end
      end
    end
  end

  initial begin
    #10;
    checks++;
    if (host_rdata !== 32'h0 || req_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: rdata=%h valid=%b expected 00000000 0", host_rdata, req_valid);
    end
    #10 rst_n = 1'b1;
    idle("R1 idle after reset");
    step(1, 32'h3A5B_0000, 0, 0, 0, 4'h0, 8'h0, 0, "R2 target fields");
    step(1, 32'h3C12_F000, 0, 0, 0, 4'h0, 8'h0, 0, "R3 spare bits written as 1");
    step(1, 32'h8C12_0000, 0, 0, 0, 4'h0, 8'h0, 0, "R4 R5 read flag set");
    step(1, 32'h0D34_0000, 0, 0, 0, 4'h0, 8'h0, 0, "R4 zero leaves flag");
    idle("R5 flag holds");
    step(0, 32'h0, 0, 1, 0, 4'h0, 8'h0, 0, "R6 sent clears read");
    step(0, 32'h0, 0, 1, 0, 4'h0, 8'h0, 0, "R6 sent while idle");
    step(1, 32'hC777_0000, 0, 0, 0, 4'h0, 8'h0, 0, "R7 both flags read first");
    step(0, 32'h0, 0, 1, 0, 4'h0, 8'h0, 0, "R7 write offered after read");
    step(0, 32'h0, 0, 1, 0, 4'h0, 8'h0, 0, "R6 write cleared");
    step(1, 32'h4199_0000, 0, 0, 0, 4'h0, 8'h0, 0, "R5 write alone");
    step(1, 32'h4199_0000, 0, 1, 0, 4'h0, 8'h0, 0, "R8 write re-armed on sent");
    step(1, 32'h8199_0000, 0, 1, 0, 4'h0, 8'h0, 0, "R6 write served, read armed");
    step(1, 32'h8199_0000, 0, 1, 0, 4'h0, 8'h0, 0, "R8 read re-armed on sent");
    step(0, 32'h0, 0, 1, 0, 4'h0, 8'h0, 0, "R6 read drained");
    step(0, 32'h0, 0, 0, 1, 4'h6, 8'hC3, 0, "R9 response captured");
    step(1, 32'h0000_0A5C, 0, 0, 0, 4'h0, 8'h0, 0, "R10 host write ignored");
    step(1, 32'h0000_0B7E, 1, 0, 0, 4'h0, 8'h0, 0, "R10 diagnostic load");
    step(1, 32'h0000_0F11, 1, 0, 1, 4'h2, 8'h9D, 0, "R11 response beats diag write");
    step(1, 32'hC5AA_0000, 0, 0, 0, 4'h0, 8'h0, 0, "R7 arm both before reset");
    step(0, 32'h0, 0, 0, 0, 4'h0, 8'h0, 1, "R1 software reset");
    step(1, 32'h8123_0FFF, 1, 1, 1, 4'h7, 8'h55, 1, "R1 sw reset overrides all");
    idle("R1 quiet after reset");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule